// File: doc/BRIEF.md
# Double-Buffered Sixteen-Channel DAC Code Register Bank

This block is the digital side of a sixteen-channel, eight-bit voltage DAC that a host programs over a parallel bus. Every channel has two registers. A staging register takes the host's writes one channel at a time. A live register holds the code that the converter uses. The host fills any number of staging registers, then issues one load strobe. That strobe copies every staging register into its live register on the same clock edge, so all sixteen outputs change together.

All bus inputs are sampled by the block clock. Actions happen on the rising (trailing) edge of the active-low strobe. A read places the addressed staging register on the data bus. The tristate is modelled as a data-out bus plus an output-enable. A clear input empties the live registers to code zero. It does not touch the staging registers.

Top module: `dac_regbank`

## Requirements
- R1: With `sel`=1 and `rw`=0, a rising edge of `en_n` stores `din` into the staging register that `addr` selects. `addr` is binary with bit 3 the most significant. In `din` and in each code, bit 0 is the least significant bit. Channel n's live code appears at `dac_codes[n*8 +: 8]`.
- R2: A write without a load leaves every live code unchanged.
- R3: A rising edge of `en_n` with `ld`=1 copies all sixteen staging registers into the live registers on one clock edge.
- R4: A load strobe with `sel`=0 still performs the transfer, and it leaves all staging registers unchanged whatever `din` and `addr` hold.
- R5: When a strobe both writes and loads, the written channel's live code takes the new `din` value.
- R6: While `sel`=1 and `rw`=1, `dout_oe` is 1 and `dout` shows the staging register at `addr`. Otherwise `dout_oe` is 0 and `dout` is zero.
- R7: `clear_n` is a synchronous active-low clear. On any edge where it is low, all live codes become zero and no strobe acts, even one that asks for a load. Staging registers keep their contents.
- R8: Inputs are registered once. A strobe's effect appears after the second rising clock edge that follows the rise of `en_n`. Holding `en_n` low or high does nothing, and a strobe with `rw`=1 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the bus |
| clear_n | input | 1 | Synchronous active-low clear of the live codes |
| sel | input | 1 | Chip select, active high |
| rw | input | 1 | 1 = read, 0 = write |
| en_n | input | 1 | Active-low strobe; acts on its rising edge |
| ld | input | 1 | Requests a transfer from staging to live registers on the strobe |
| addr | input | 4 | Channel address |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Readback data, zero when not driving |
| dout_oe | output | 1 | High while the block drives the data bus |
| dac_codes | output | 128 | Sixteen live codes, channel n at bits n*8+7..n*8 |

## Verification
The bench uses the default build of sixteen channels and eight-bit codes. With these values the four-bit address spans every channel, and each address value has a register behind it. A random walk then reaches the top and bottom channels, codes 00 and FF, and strobes that write and load at once. It also reaches strobes that coincide with a clear. Directed passes cover the bit order of the code and address fields, keeping the staging registers through a clear, and the deselected load.

// File: rtl/dac_regbank_pkg.sv
// Shared types for the DAC code register bank.
package dac_regbank_pkg;

    // One decoded strobe: what the trailing edge of the strobe asks for.
    typedef struct packed {
        logic write;   // store bus data into one staging register
        logic load;    // copy all staging registers into live registers
    } bank_stb_t;

endpackage

// File: rtl/dac_bus_sampler.sv
// Registers the parallel bus once and turns the trailing edge of the
// active-low strobe into one-cycle write and load pulses.
// Assumes: all bus inputs are stable around the strobe's rising edge.
// The clear forces the strobe history high, so no edge is seen while
// the clear is low.
module dac_bus_sampler
    import dac_regbank_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              clear_n,
    input  logic              sel,
    input  logic              rw,
    input  logic              en_n,
    input  logic              ld,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CODE_W-1:0] din,
    output bank_stb_t         stb,
    output logic [ADDR_W-1:0] s_addr,
    output logic [CODE_W-1:0] s_din,
    output logic              rd_en
);

    logic s_sel, s_rw, s_ld, s_en_n, s_en_d;
    logic en_rise;

    // Capture the bus and keep one cycle of strobe history.
    always_ff @(posedge clk) begin
        if (!clear_n) begin
            s_sel  <= 1'b0;
            s_rw   <= 1'b0;
            s_ld   <= 1'b0;
            s_en_n <= 1'b1;
            s_en_d <= 1'b1;
            s_addr <= '0;
            s_din  <= '0;
        end else begin
            s_sel  <= sel;
            s_rw   <= rw;
            s_ld   <= ld;
            s_en_n <= en_n;
            s_en_d <= s_en_n;
            s_addr <= addr;
            s_din  <= din;
        end
    end

    // Decode the trailing strobe edge into actions; none act during clear.
    always_comb begin
        en_rise   = s_en_n & ~s_en_d;
        stb.write = en_rise & s_sel & ~s_rw & clear_n;
        stb.load  = en_rise & s_ld & clear_n;
        rd_en     = s_sel & s_rw;
    end

endmodule

// File: rtl/dac_input_bank.sv
// Staging registers, one per channel, written one at a time, plus the
// readback multiplexer.
// Assumes: writes are single-cycle pulses. The staging registers have no
// reset and keep their contents through a clear. Addresses at or above
// NUM_CH select nothing and read back as zero.
module dac_input_bank #(
    parameter int NUM_CH = 16,
    parameter int CODE_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     wr,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [CODE_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [NUM_CH*CODE_W-1:0] in_codes,
    output logic [CODE_W-1:0]        rd_data
);

    genvar ch;
    generate
        for (ch = 0; ch < NUM_CH; ch++) begin : g_stage
            // Store bus data when this channel is addressed by a write.
            always_ff @(posedge clk) begin
                if (wr && (wr_addr == ADDR_W'(ch)))
                    in_codes[ch*CODE_W +: CODE_W] <= wr_data;
            end
        end
    endgenerate

    // Select the addressed staging register for readback.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (rd_addr == ADDR_W'(i))
                rd_data = in_codes[i*CODE_W +: CODE_W];
    end

endmodule

// File: rtl/dac_output_bank.sv
// Live code registers. A load copies every staging register at once. A
// write in the same cycle passes through to its own channel, so a
// combined write-and-load strobe shows the new code.
// Assumes: the clear is synchronous, active low, and wins over a load.
module dac_output_bank #(
    parameter int NUM_CH = 16,
    parameter int CODE_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     clear_n,
    input  logic                     load,
    input  logic                     wr,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [CODE_W-1:0]        wr_data,
    input  logic [NUM_CH*CODE_W-1:0] in_codes,
    output logic [NUM_CH*CODE_W-1:0] dac_codes
);

    genvar ch;
    generate
        for (ch = 0; ch < NUM_CH; ch++) begin : g_live
            logic [CODE_W-1:0] next_code;

            // Pick the staged code, or the code being written right now.
            always_comb begin
                if (wr && (wr_addr == ADDR_W'(ch)))
                    next_code = wr_data;
                else
                    next_code = in_codes[ch*CODE_W +: CODE_W];
            end

            // Clear to zero, or take the new code on a load.
            always_ff @(posedge clk) begin
                if (!clear_n)
                    dac_codes[ch*CODE_W +: CODE_W] <= '0;
                else if (load)
                    dac_codes[ch*CODE_W +: CODE_W] <= next_code;
            end
        end
    endgenerate

endmodule

// File: rtl/dac_regbank.sv
// Top of the double-buffered DAC code register bank. It samples the
// parallel bus, stages writes per channel, and moves all staged codes to
// the live codes on a load strobe. Readback shows the staged codes on a
// data-out bus with an output-enable.
// Assumes: one clock domain. The bus is asynchronous to clk but slow
// enough that each strobe phase spans at least two clock cycles.
module dac_regbank
    import dac_regbank_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CODE_W = 8,
    localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int BUS_W  = NUM_CH * CODE_W
) (
    input  logic              clk,
    input  logic              clear_n,
    input  logic              sel,
    input  logic              rw,
    input  logic              en_n,
    input  logic              ld,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CODE_W-1:0] din,
    output logic [CODE_W-1:0] dout,
    output logic              dout_oe,
    output logic [BUS_W-1:0]  dac_codes
);

    bank_stb_t         stb;
    logic [ADDR_W-1:0] s_addr;
    logic [CODE_W-1:0] s_din;
    logic              rd_en;
    logic [BUS_W-1:0]  in_codes;
    logic [CODE_W-1:0] rd_data;

    dac_bus_sampler #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) sampler_i (
        .clk     (clk),
        .clear_n (clear_n),
        .sel     (sel),
        .rw      (rw),
        .en_n    (en_n),
        .ld      (ld),
        .addr    (addr),
        .din     (din),
        .stb     (stb),
        .s_addr  (s_addr),
        .s_din   (s_din),
        .rd_en   (rd_en)
    );

    dac_input_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) stage_i (
        .clk      (clk),
        .wr       (stb.write),
        .wr_addr  (s_addr),
        .wr_data  (s_din),
        .rd_addr  (s_addr),
        .in_codes (in_codes),
        .rd_data  (rd_data)
    );

    dac_output_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) live_i (
        .clk       (clk),
        .clear_n   (clear_n),
        .load      (stb.load),
        .wr        (stb.write),
        .wr_addr   (s_addr),
        .wr_data   (s_din),
        .in_codes  (in_codes),
        .dac_codes (dac_codes)
    );

    // Drive readback only while a read is selected.
    always_comb begin
        dout_oe = rd_en;
        dout    = rd_en ? rd_data : '0;
    end

endmodule

// File: rtl/dac_regbank_chk.sv
// Property checker for dac_regbank, attached by bind below. It relates
// bus inputs two edges back to changes on the staged and live codes.
module dac_regbank_chk #(
    parameter int NUM_CH = 16,
    parameter int CODE_W = 8
) (
    input logic                     clk,
    input logic                     clear_n,
    input logic                     sel,
    input logic                     rw,
    input logic                     ld,
    input logic                     dout_oe,
    input logic [NUM_CH*CODE_W-1:0] dac_codes,
    input logic [NUM_CH*CODE_W-1:0] in_codes
);

    logic started = 1'b0;
    logic clr_q   = 1'b1;

    // R7: one edge after a low clear, every live code reads zero.
    always @(posedge clk) begin
        if (started && !clr_q)
            assert_clear_zero_R7: assert (dac_codes == '0)
                else $error("live codes not cleared");
        clr_q   <= clear_n;
        started <= 1'b1;
    end

    // R6: a selected read enables the bus one edge later.
    assert_read_drives_R6: assert property (@(posedge clk) disable iff (!clear_n)
        (sel && rw) |=> dout_oe);

    // R6: anything other than a selected read releases the bus.
    assert_idle_release_R6: assert property (@(posedge clk) disable iff (!clear_n)
        !(sel && rw) |=> !dout_oe);

    // R2: live codes move only after a load request, outside a clear.
    assert_live_needs_load_R2: assert property (@(posedge clk) disable iff (!clear_n)
        ($past(clear_n) && !$stable(dac_codes)) |-> $past(ld, 2));

    // R4: staging registers change only after a selected write.
    assert_stage_needs_write_R4: assert property (@(posedge clk) disable iff (!clear_n)
        !$stable(in_codes) |-> ($past(sel, 2) && !$past(rw, 2)));

endmodule

bind dac_regbank dac_regbank_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) chk_i (
    .clk       (clk),
    .clear_n   (clear_n),
    .sel       (sel),
    .rw        (rw),
    .ld        (ld),
    .dout_oe   (dout_oe),
    .dac_codes (dac_codes),
    .in_codes  (in_codes)
);

// File: tb/dac_regbank_tb_top.sv
// Bench: a behavioural model with two cycles of bus history, compared on
// every falling edge, plus directed checks.
module dac_regbank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16;
    localparam int CW  = 8;
    localparam int AW  = 4;

    logic            clk = 1'b0;
    logic            clear_n = 1'b0;
    logic            sel = 1'b0, rw = 1'b0, en_n = 1'b1, ld = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [CW-1:0]   din = '0;
    logic [CW-1:0]   dout;
    logic            dout_oe;
    logic [NCH*CW-1:0] dac_codes;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    string cur_req = "R7";

    dac_regbank #(.NUM_CH(NCH), .CODE_W(CW)) dut_i (
        .clk(clk), .clear_n(clear_n), .sel(sel), .rw(rw), .en_n(en_n),
        .ld(ld), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
        .dac_codes(dac_codes)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state.
    int m_in [NCH];
    bit m_known [NCH];
    int m_dac [NCH];
    bit m_valid = 0;
    bit m_oe = 0;
    int m_raddr = 0;
    bit h1_en = 1, h1_sel = 0, h1_rw = 0, h1_ld = 0;
    int h1_addr = 0, h1_din = 0;
    bit h2_en = 1;

    always @(posedge clk) begin
        cycles++;
        if (!clear_n) begin
            for (int i = 0; i < NCH; i++) m_dac[i] = 0;
            h2_en = 1; h1_en = 1; h1_sel = 0; h1_rw = 0; h1_ld = 0;
            h1_addr = 0; h1_din = 0;
            m_oe = 0; m_raddr = 0; m_valid = 1;
        end else begin
            if (h1_en && !h2_en) begin
                if (h1_sel && !h1_rw) begin
                    m_in[h1_addr] = h1_din;
                    m_known[h1_addr] = 1;
                end
                if (h1_ld)
                    for (int i = 0; i < NCH; i++) m_dac[i] = m_in[i];
            end
            h2_en = h1_en;
            h1_en = en_n; h1_sel = sel; h1_rw = rw; h1_ld = ld;
            h1_addr = int'(addr); h1_din = int'(din);
            m_oe = sel && rw;
            m_raddr = int'(addr);
        end
    end

    task automatic check(input string req, input int got, input int exp, input string what);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, got, exp, $time);
        end
    endtask

    // Compare DUT outputs against the model every cycle.
    always @(negedge clk) begin
        if (m_valid) begin
            for (int i = 0; i < NCH; i++)
                if (int'(dac_codes[i*CW +: CW]) != m_dac[i])
                    check(cur_req, int'(dac_codes[i*CW +: CW]), m_dac[i], $sformatf("live code ch%0d", i));
            check(cur_req, int'(dout_oe), int'(m_oe), "dout_oe");
            if (!m_oe)
                check(cur_req, int'(dout), 0, "idle dout");
            else if (m_known[m_raddr])
                check(cur_req, int'(dout), m_in[m_raddr], "readback");
        end
    end

    task automatic strobe(input bit s, input bit r, input bit l,
                          input int a, input int d, input int low_cyc);
        @(negedge clk);
        sel = s; rw = r; ld = l; addr = AW'(a); din = CW'(d); en_n = 1'b0;
        repeat (low_cyc) @(negedge clk);
        en_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    function automatic int live(input int ch);
        return int'(dac_codes[ch*CW +: CW]);
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        if (cycles > 100000) begin
            n_fails++; n_checks++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
            finish_run();
        end
    end

    initial begin
        int seed;
        for (int i = 0; i < NCH; i++) begin m_in[i] = 0; m_known[i] = 0; m_dac[i] = 0; end
        // R7: reset state.
        repeat (3) @(negedge clk);
        check("R7", int'(dac_codes == '0), 1, "live codes zero after clear");
        check("R6", int'(dout_oe), 0, "bus released after clear");
        clear_n = 1'b1;

        // R1, R2: fill all staging registers, no load.
        cur_req = "R2";
        for (int c = 0; c < NCH; c++) strobe(1, 0, 0, c, c * 17 + 3, 2);
        check("R2", int'(dac_codes == '0), 1, "no live change without load");

        // R6, R1: read each back.
        cur_req = "R6";
        for (int c = 0; c < NCH; c++) begin
            strobe(1, 1, 0, c, 0, 2);
            check("R1", int'(dout), (c * 17 + 3) & 8'hFF, $sformatf("readback ch%0d", c));
        end
        strobe(0, 1, 0, 3, 0, 2);
        check("R6", int'(dout_oe), 0, "deselected read releases bus");

        // R4, R3: deselected load transfers everything, staging untouched.
        cur_req = "R4";
        strobe(0, 0, 1, 0, 8'hFF, 2);
        check("R3", live(0), 3, "ch0 loaded");
        check("R3", live(15), (15 * 17 + 3) & 8'hFF, "ch15 loaded");
        strobe(1, 1, 0, 0, 0, 2);
        check("R4", int'(dout), 3, "ch0 staging unchanged by deselected load");

        // R5: write and load together, with bit order at address bit 3.
        cur_req = "R5";
        strobe(1, 0, 1, 8, 8'h01, 2);
        check("R5", live(8), 1, "write-through on combined strobe");
        check("R1", int'(dac_codes[64]), 1, "bit 0 is code LSB at ch8");
        check("R5", live(7), 7 * 17 + 3, "neighbour takes staged code");

        // R8: held strobe, read strobe with data, timing of an update.
        cur_req = "R8";
        @(negedge clk);
        sel = 1; rw = 1; ld = 0; addr = 4'd2; din = 8'h5A; en_n = 1'b0;
        repeat (6) @(negedge clk);
        en_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R8", int'(dout), 2 * 17 + 3, "read strobe writes nothing");
        @(negedge clk);
        sel = 1; rw = 0; ld = 1; addr = 4'd4; din = 8'hC3; en_n = 1'b0;
        repeat (2) @(negedge clk);
        en_n = 1'b1;
        @(negedge clk);
        check("R8", live(4), 4 * 17 + 3, "no update one edge after rise");
        @(negedge clk);
        check("R8", live(4), 8'hC3, "update two edges after rise");
        repeat (2) @(negedge clk);

        // R7: clear on a load strobe wins; staging kept.
        cur_req = "R7";
        @(negedge clk);
        sel = 1; rw = 0; ld = 1; addr = 4'd9; din = 8'hEE; en_n = 1'b0;
        repeat (2) @(negedge clk);
        en_n = 1'b1; clear_n = 1'b0;
        repeat (3) @(negedge clk);
        clear_n = 1'b1;
        @(negedge clk);
        check("R7", int'(dac_codes == '0), 1, "clear beats load");
        strobe(1, 1, 0, 9, 0, 2);
        check("R7", int'(dout), 9 * 17 + 3, "staging kept through clear");

        // Random walk across all requirements.
        cur_req = "R3";
        seed = 7;
        for (int k = 0; k < 600; k++) begin
            int op;
            seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
            op = (seed >> 8) % 20;
            if (op == 0) begin
                @(negedge clk); clear_n = 1'b0;
                repeat (2) @(negedge clk); clear_n = 1'b1;
            end else begin
                strobe(((seed >> 3) & 3) != 0, ((seed >> 5) & 3) == 0, ((seed >> 7) & 1) == 1,
                       (seed >> 12) % NCH, (seed >> 16) & 8'hFF, 2 + ((seed >> 2) & 1));
            end
        end
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule